// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block lets a two-wire bus controller bring the bus back to a known state after a transfer was cut short, for example by a reset of the controller while a target was still shifting out a byte. On a single-cycle trigger it plays a fixed waveform on the clock line and on the open-drain data enable. The waveform is a Start condition, nine clock pulses with data released, a repeated Start, and a Stop. The nine pulses let any target that is still holding data low finish its byte and let go of the line.

Every interval of the waveform is a count of system clock cycles given as a module parameter. Separate counts cover the clock low and high times, the Start setup and hold, the Stop setup, the data hold after the first Start, and the bus-free gap. At 400 kHz the low time must be at least 1.3 us, the high time and the Start and Stop setup and hold times at least 0.6 us, and the bus-free gap at least 1.3 us. The block reports busy while the waveform runs. It pulses done for one cycle when the bus-free gap has elapsed.

Top module: `twb_recover_seq`

## Requirements
- R1: After reset, and whenever busy_o is low, scl_o is 1 (clock released high) and sda_oe_o is 0 (data released). done_o is low after reset.
- R2: A start_i seen high at a clock edge while busy_o is low makes busy_o high from that edge. The first interval then holds scl_o=1, sda_oe_o=0 for T_SU_STA cycles.
- R3: The first Start pulls data low (sda_oe_o=1) with scl_o=1 for T_HD_STA cycles. Then scl_o goes to 0 with data still held low for T_HD_DAT cycles.
- R4: Exactly N_PULSE clock pulses follow with sda_oe_o=0 throughout. Each pulse is scl_o=0 for T_LOW cycles and then scl_o=1 for T_HIGH cycles.
- R5: After the last pulse, scl_o=0 for T_LOW cycles and then scl_o=1 with data released for T_SU_STA cycles. Data is then pulled low with scl_o=1 for T_HD_STA cycles (repeated Start).
- R6: The Stop is scl_o=0 with sda_oe_o=1 for T_LOW cycles, then scl_o=1 with sda_oe_o=1 for T_SU_STO cycles. Data is then released while scl_o stays 1.
- R7: After the Stop, both lines stay released for T_BUF cycles with busy_o high. done_o is then high for exactly one cycle, the same cycle in which busy_o first reads low.
- R8: start_i has no effect while busy_o is high. The waveform is unchanged, and no new sequence begins after done_o.
- R9: scl_o and sda_oe_o never change in the same cycle.
- R10: A start_i given in the cycle where done_o is high is accepted, and the full waveform is produced again with the pulse count starting from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Trigger; sampled only while idle |
| scl_o | output | 1 | Clock line level: 1 releases the line high, 0 drives it low |
| sda_oe_o | output | 1 | Open-drain data enable: 1 pulls data low, 0 releases it |
| busy_o | output | 1 | High while the recovery waveform is running |
| done_o | output | 1 | One-cycle pulse when the bus-free gap ends |

## Verification
The bench records the whole waveform as a list of intervals of constant line levels and compares it with a list built from the parameter values. Each parameter is given a distinct value, so a design that swapped two counts, missed the data hold after the first Start, or gave the Stop setup the wrong length produces a different list. A pulse counter that is off by one shows up as 8 or 10 pulses. A counter that is not cleared between runs shortens the back-to-back run. A design that accepted a trigger while busy would restart the waveform or run a second sequence after done. A reset in the middle of a run must release both lines at once.

// File: rtl/twb_rec_pkg.sv
package twb_rec_pkg;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_S_SU,
    PH_S_HD,
    PH_S_DROP,
    PH_CK_LO,
    PH_CK_HI,
    PH_R_LO,
    PH_R_SU,
    PH_R_HD,
    PH_P_LO,
    PH_P_SU,
    PH_FREE
  } phase_e;

  typedef struct packed {
    logic scl;
    logic sda_low;
  } bus_drv_t;

  // line levels held during each phase
  function automatic bus_drv_t drive_of(phase_e ph);
    bus_drv_t d;
    case (ph)
      PH_S_HD:   d = '{scl: 1'b1, sda_low: 1'b1};
      PH_S_DROP: d = '{scl: 1'b0, sda_low: 1'b1};
      PH_CK_LO:  d = '{scl: 1'b0, sda_low: 1'b0};
      PH_R_LO:   d = '{scl: 1'b0, sda_low: 1'b0};
      PH_R_HD:   d = '{scl: 1'b1, sda_low: 1'b1};
      PH_P_LO:   d = '{scl: 1'b0, sda_low: 1'b1};
      PH_P_SU:   d = '{scl: 1'b1, sda_low: 1'b1};
      default:   d = '{scl: 1'b1, sda_low: 1'b0};
    endcase
    return d;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/twb_rec_timer.sv
module twb_rec_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/twb_rec_pulse_ctr.sv
module twb_rec_pulse_ctr #(
  parameter int unsigned N_PULSE = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic step,
  output logic last
);
  localparam int unsigned PW = $clog2(N_PULSE + 1);
  localparam logic [PW-1:0] LAST_IDX = PW'(N_PULSE - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (step)    cnt_q <= cnt_q + 1'b1;
  end

  assign last = (cnt_q == LAST_IDX);
endmodule

// File: rtl/twb_rec_fsm.sv
module twb_rec_fsm
  import twb_rec_pkg::*;
#(
  parameter int unsigned T_LOW    = 163,
  parameter int unsigned T_HIGH   = 75,
  parameter int unsigned T_SU_STA = 75,
  parameter int unsigned T_HD_STA = 75,
  parameter int unsigned T_SU_STO = 75,
  parameter int unsigned T_HD_DAT = 2,
  parameter int unsigned T_BUF    = 163,
  parameter int unsigned CW       = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          tmr_zero,
  input  logic          pulse_last,
  output phase_e        phase_q,
  output phase_e        phase_d,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          pulse_clear,
  output logic          pulse_step
);

  function automatic logic [CW-1:0] len_of(phase_e ph);
    case (ph)
      PH_S_SU, PH_R_SU:           return CW'(T_SU_STA - 1);
      PH_S_HD, PH_R_HD:           return CW'(T_HD_STA - 1);
      PH_S_DROP:                  return CW'(T_HD_DAT - 1);
      PH_CK_LO, PH_R_LO, PH_P_LO: return CW'(T_LOW - 1);
      PH_CK_HI:                   return CW'(T_HIGH - 1);
      PH_P_SU:                    return CW'(T_SU_STO - 1);
      PH_FREE:                    return CW'(T_BUF - 1);
      default:                    return '0;
    endcase
  endfunction

  logic accept;
  assign accept = (phase_q == PH_IDLE) && start_i;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE:   if (start_i)  phase_d = PH_S_SU;
      PH_S_SU:   if (tmr_zero) phase_d = PH_S_HD;
      PH_S_HD:   if (tmr_zero) phase_d = PH_S_DROP;
      PH_S_DROP: if (tmr_zero) phase_d = PH_CK_LO;
      PH_CK_LO:  if (tmr_zero) phase_d = PH_CK_HI;
      PH_CK_HI:  if (tmr_zero) phase_d = pulse_last ? PH_R_LO : PH_CK_LO;
      PH_R_LO:   if (tmr_zero) phase_d = PH_R_SU;
      PH_R_SU:   if (tmr_zero) phase_d = PH_R_HD;
      PH_R_HD:   if (tmr_zero) phase_d = PH_P_LO;
      PH_P_LO:   if (tmr_zero) phase_d = PH_P_SU;
      PH_P_SU:   if (tmr_zero) phase_d = PH_FREE;
      PH_FREE:   if (tmr_zero) phase_d = PH_IDLE;
      default:                 phase_d = PH_IDLE;
    endcase
  end

  assign tmr_load    = (phase_d != phase_q);
  assign tmr_val     = len_of(phase_d);
  assign pulse_clear = accept;
  assign pulse_step  = (phase_q == PH_CK_HI) && tmr_zero;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_IDLE;
    else     phase_q <= phase_d;
  end
endmodule

// File: rtl/twb_rec_outreg.sv
module twb_rec_outreg
  import twb_rec_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_e phase_q,
  input  phase_e phase_d,
  output logic   scl_o,
  output logic   sda_oe_o,
  output logic   busy_o,
  output logic   done_o
);
  bus_drv_t nxt;
  assign nxt = drive_of(phase_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_o    <= 1'b1;
      sda_oe_o <= 1'b0;
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      scl_o    <= nxt.scl;
      sda_oe_o <= nxt.sda_low;
      busy_o   <= (phase_d != PH_IDLE);
      done_o   <= (phase_q == PH_FREE) && (phase_d == PH_IDLE);
    end
  end
endmodule

// File: rtl/twb_recover_seq.sv
module twb_recover_seq
  import twb_rec_pkg::*;
#(
  parameter int unsigned T_LOW    = 163,
  parameter int unsigned T_HIGH   = 75,
  parameter int unsigned T_SU_STA = 75,
  parameter int unsigned T_HD_STA = 75,
  parameter int unsigned T_SU_STO = 75,
  parameter int unsigned T_HD_DAT = 2,
  parameter int unsigned T_BUF    = 163,
  parameter int unsigned N_PULSE  = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic scl_o,
  output logic sda_oe_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned MAXT = max2(max2(max2(T_LOW, T_HIGH), max2(T_SU_STA, T_HD_STA)),
                                      max2(max2(T_SU_STO, T_HD_DAT), T_BUF));
  localparam int unsigned CW   = $clog2(MAXT + 1);

  phase_e        phase_q, phase_d;
  logic          tmr_load, tmr_zero;
  logic [CW-1:0] tmr_val;
  logic          pulse_clear, pulse_step, pulse_last;

  twb_rec_fsm #(
    .T_LOW(T_LOW), .T_HIGH(T_HIGH), .T_SU_STA(T_SU_STA), .T_HD_STA(T_HD_STA),
    .T_SU_STO(T_SU_STO), .T_HD_DAT(T_HD_DAT), .T_BUF(T_BUF), .CW(CW)
  ) fsm_i (
    .clk(clk), .rst(rst), .start_i(start_i), .tmr_zero(tmr_zero),
    .pulse_last(pulse_last), .phase_q(phase_q), .phase_d(phase_d),
    .tmr_load(tmr_load), .tmr_val(tmr_val),
    .pulse_clear(pulse_clear), .pulse_step(pulse_step)
  );

  twb_rec_timer #(.CW(CW)) tmr_i (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  twb_rec_pulse_ctr #(.N_PULSE(N_PULSE)) pcnt_i (
    .clk(clk), .rst(rst), .clear(pulse_clear), .step(pulse_step), .last(pulse_last)
  );

  twb_rec_outreg out_i (
    .clk(clk), .rst(rst), .phase_q(phase_q), .phase_d(phase_d),
    .scl_o(scl_o), .sda_oe_o(sda_oe_o), .busy_o(busy_o), .done_o(done_o)
  );
endmodule

// File: rtl/twb_recover_chk.sv
module twb_recover_chk #(
  parameter int unsigned T_LOW    = 163,
  parameter int unsigned T_HIGH   = 75,
  parameter int unsigned T_SU_STA = 75,
  parameter int unsigned T_HD_STA = 75
) (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic scl_o,
  input logic sda_oe_o,
  input logic busy_o,
  input logic done_o
);
  localparam int unsigned FIRST_HI = T_SU_STA + T_HD_STA;
  localparam int unsigned MIN_HI   = (T_HIGH < FIRST_HI) ? T_HIGH : FIRST_HI;

  int unsigned low_run, high_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_run  <= 0;
      high_run <= 0;
    end else begin
      low_run  <= scl_o ? 0 : low_run + 1;
      high_run <= scl_o ? high_run + 1 : 0;
    end
  end

  a_r1_idle_released: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (scl_o && !sda_oe_o));

  a_r2_start_taken: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i) |=> busy_o);

  a_r4_low_time: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_o) |-> (low_run >= T_LOW));

  a_r4_high_time: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_o) |-> (high_run >= MIN_HI));

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)));

  a_r7_busy_ends_with_done: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> (busy_o || done_o));

  a_r9_one_line_moves: assert property (@(posedge clk) disable iff (rst)
    !$stable(scl_o) |-> $stable(sda_oe_o));
endmodule

bind twb_recover_seq twb_recover_chk #(
  .T_LOW(T_LOW), .T_HIGH(T_HIGH), .T_SU_STA(T_SU_STA), .T_HD_STA(T_HD_STA)
) chk_i (
  .clk(clk), .rst(rst), .start_i(start_i), .scl_o(scl_o),
  .sda_oe_o(sda_oe_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/twb_recover_seq_tb_top.sv
`timescale 1ns/1ps
module twb_recover_seq_tb_top;
  localparam int T_LOW = 7, T_HIGH = 5, T_SU_STA = 4, T_HD_STA = 3;
  localparam int T_SU_STO = 6, T_HD_DAT = 2, T_BUF = 9, N_PULSE = 9;
  localparam int NSEG = 3 + 2 * N_PULSE + 6;

  logic clk = 1'b0, rst = 1'b1, start_i = 1'b0;
  logic scl_o, sda_oe_o, busy_o, done_o;

  int n_tests = 0, n_fail = 0;

  int exp_s[64], exp_o[64], exp_n[64], n_exp;
  int got_s[64], got_o[64], got_n[64], n_got;
  bit both_moved;

  always #4 clk = ~clk;

  twb_recover_seq #(
    .T_LOW(T_LOW), .T_HIGH(T_HIGH), .T_SU_STA(T_SU_STA), .T_HD_STA(T_HD_STA),
    .T_SU_STO(T_SU_STO), .T_HD_DAT(T_HD_DAT), .T_BUF(T_BUF), .N_PULSE(N_PULSE)
  ) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .scl_o(scl_o),
    .sda_oe_o(sda_oe_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic add_exp(input int s, input int o, input int n);
    exp_s[n_exp] = s; exp_o[n_exp] = o; exp_n[n_exp] = n; n_exp++;
  endtask

  task automatic build_expected();
    n_exp = 0;
    add_exp(1, 0, T_SU_STA);                      // R2
    add_exp(1, 1, T_HD_STA);                      // R3
    add_exp(0, 1, T_HD_DAT);                      // R3
    for (int i = 0; i < N_PULSE; i++) begin       // R4
      add_exp(0, 0, T_LOW);
      add_exp(1, 0, T_HIGH);
    end
    add_exp(0, 0, T_LOW);                         // R5
    add_exp(1, 0, T_SU_STA);                      // R5
    add_exp(1, 1, T_HD_STA);                      // R5
    add_exp(0, 1, T_LOW);                         // R6
    add_exp(1, 1, T_SU_STO);                      // R6
    add_exp(1, 0, T_BUF);                         // R7
  endtask

  function automatic string req_of(input int idx);
    if (idx == 0) return "R2";
    if (idx <= 2) return "R3";
    if (idx <= 2 + 2 * N_PULSE) return "R4";
    if (idx <= 5 + 2 * N_PULSE) return "R5";
    if (idx <= 7 + 2 * N_PULSE) return "R6";
    return "R7";
  endfunction

  // Raise start at the current negedge and record the waveform until busy drops.
  // poke > 0 keeps pulsing start every poke cycles while busy (R8 stimulus).
  task automatic run_seq(input int poke, input string tag);
    int cyc = 0;
    int ps = 1, po = 0;
    n_got = 0; both_moved = 0;
    start_i = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) check(tag, busy_o, 1, "busy after start");
      if (!busy_o || cyc > 5000) break;
      if (n_got > 0 && scl_o == got_s[n_got-1] && sda_oe_o == got_o[n_got-1]) begin
        got_n[n_got-1]++;
      end else if (n_got < 64) begin
        got_s[n_got] = scl_o; got_o[n_got] = sda_oe_o; got_n[n_got] = 1; n_got++;
      end
      if (scl_o != ps && sda_oe_o != po) both_moved = 1;
      ps = scl_o; po = sda_oe_o;
      start_i = (poke > 0) && (cyc % poke == 0);
    end
    start_i = 1'b0;
    check("R7", (cyc > 5000) ? 0 : 1, 1, "sequence finished");
    check("R7", done_o, 1, "done with busy low");
    check("R9", both_moved, 0, "scl and sda moved together");
  endtask

  task automatic compare_trace(input string tag);
    check("R4", n_got, n_exp, {tag, " interval count"});
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      check(req_of(i), got_s[i] * 2 + got_o[i], exp_s[i] * 2 + exp_o[i],
            $sformatf("%s interval %0d levels (scl*2+oe)", tag, i));
      check(req_of(i), got_n[i], exp_n[i], $sformatf("%s interval %0d length", tag, i));
    end
  endtask

  task automatic expect_idle(input string req, input string what);
    check(req, scl_o, 1, {what, " scl"});
    check(req, sda_oe_o, 0, {what, " sda_oe"});
    check(req, busy_o, 0, {what, " busy"});
    check(req, done_o, 0, {what, " done"});
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_idle("R1", "after reset");
  endtask

  task automatic test_basic();
    run_seq(0, "R2");
    compare_trace("basic");
    @(negedge clk);
    expect_idle("R7", "cycle after done");
  endtask

  task automatic test_ignore_busy();
    run_seq(3, "R8");
    compare_trace("R8 pulsed start");
    @(negedge clk);
    expect_idle("R8", "no restart after done");
    run_seq(1, "R8");
    compare_trace("R8 held start");
    @(negedge clk);
    expect_idle("R8", "no restart after held start");
  endtask

  task automatic test_back_to_back();
    run_seq(0, "R10");
    run_seq(0, "R10");
    compare_trace("R10 second run");
    @(negedge clk);
  endtask

  task automatic test_mid_reset();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (40) @(negedge clk);
    check("R1", busy_o, 1, "busy before mid-run reset");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    expect_idle("R1", "mid-run reset");
    repeat (2) @(negedge clk);
    expect_idle("R1", "idle after mid-run reset");
    run_seq(0, "R1");
    compare_trace("R1 after reset");
    @(negedge clk);
  endtask

  initial begin
    build_expected();
    test_reset();
    test_basic();
    test_ignore_busy();
    test_back_to_back();
    test_mid_reset();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule